// File: doc/BRIEF.md
# Flash program/erase command sequencer

This block is the control state machine that sits in front of an embedded flash array. A register-side interface sends program, erase, suspend and resume commands, a mode-entry bit that selects between command mode and array read mode, and a controller reset bit. The block answers with a status word: ready, suspend-ready, program-held, erase-held and four sticky error flags. The array itself is not modelled. Each program or erase is a busy period of fixed length, counted down by an internal timer. The array can report a failure at the end of an operation, and a separate input flags an internal controller fault.

An erase can be paused so that another block can be programmed. The erase then resumes with the work it had left. The suspend handshake gives a defined result when it meets the end of an operation. If the operation finished earlier, the suspend is an error. If it finishes on the cycle the suspend is taken, the operation simply completes. Any illegal command, and any reported failure, locks the controller with ready high until the reset bit has been held for a minimum number of cycles. Read access to the array is exposed only as an enable output.

Top module: `flash_seq`

## Requirements
- R1: After the synchronous reset `rst`, ready is 1. Mode entry, the suspend-ready flag, both held flags and all four error flags are 0, and the read enable is 1.
- R2: A command is ignored while mode entry is 0, with no status change and no error. A mode write with value 1 is taken only while the controller is idle. The read enable is 1 exactly when mode entry is 0 and the reset bit was 0 on the previous edge.
- R3: The command codes on `cmd_op` are 1 for program, 2 for erase, 3 for suspend and 4 for resume. Every other code is illegal. An accepted program drops ready to 0 for exactly PROG_CYC cycles, and an accepted erase drops it for exactly ERASE_CYC cycles.
- R4: Suspend-ready is 1 only during a running main program or erase that has run at least SUS_RDY_CYC cycles since it started or resumed. A suspend taken while suspend-ready is 0, including one taken while the controller is idle after an operation has finished, sets the illegal-command error.
- R5: An accepted suspend keeps ready at 0 for SUS_LAT further cycles. Ready then returns to 1, with exactly one held flag set: the program-held flag for a program and the erase-held flag for an erase.
- R6: A suspend accepted on the last busy cycle of an operation raises no error. Ready returns to 1 and both held flags stay 0.
- R7: An accepted resume clears the held flag and drops ready to 0. The held operation then runs for exactly the busy cycles it had left, which is its full length minus the busy cycles it had run before the suspend edge.
- R8: A resume while neither held flag is 1 sets the illegal-command error.
- R9: While an erase is held, a program to any block other than the erase target is accepted. It runs for PROG_CYC cycles with the erase-held flag kept at 1 and then returns to the erase-held state. A program to the erase-target block sets the illegal-command error.
- R10: A mode write with value 0 from either held state abandons the held operation. The controller is left idle with ready 1, both held flags 0, mode entry 0 and the read enable 1.
- R11: Error flags are sticky. While any error flag is set, ready is 1, both held flags are 0 and every command is ignored.
- R12: While the reset bit is 1, any operation is aborted, mode entry is forced to 0, commands and mode writes are ignored, and the read enable is 0. The error flags clear on the RST_MIN-th consecutive cycle of the reset bit being 1. A shorter pulse leaves them set.
- R13: An array failure reported on the last busy cycle sets the program error for a program, including one run while an erase is held, and sets the erase error for an erase. A controller fault sets the internal error whenever the reset bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code |
| cmd_blk | input | BLK_W | Target block of a program or erase |
| mode_wr | input | 1 | Write strobe for the mode-entry bit |
| mode_val | input | 1 | Value written to mode entry |
| ctl_reset | input | 1 | Controller reset bit |
| array_fault | input | 1 | Array reports failure of the finishing operation |
| ctl_fault | input | 1 | Internal controller fault |
| mode_entry | output | 1 | Mode-entry bit (1 = command mode) |
| rd_en | output | 1 | Array read enable |
| st_ready | output | 1 | Ready for a command |
| st_susp_ok | output | 1 | Suspend would be accepted |
| st_prg_held | output | 1 | Program is suspended |
| st_ers_held | output | 1 | Erase is suspended |
| err_illegal | output | 1 | Illegal command, controller locked |
| err_prog | output | 1 | Program failed |
| err_erase | output | 1 | Erase failed |
| err_internal | output | 1 | Internal controller fault |

## Verification
Every status and error flag shows the effect of an input on the first clock edge after the input is presented. The read enable follows the reset bit by one edge. The ready-low windows last PROG_CYC, ERASE_CYC, SUS_LAT and the remaining-count intervals. The bench drives inputs on the falling edge and samples on the next falling edge. Busy windows are measured by counting falling edges until ready returns, and each count is compared with a value worked out by a bench function from the command lengths and the chosen suspend point. The suspend race is placed on the exact last busy cycle by counting from the accept edge.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_SUSP   = 3'd3,
    OP_RESUME = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_ERASE,
    ST_PROG_IN_ES,
    ST_SUSP_WAIT,
    ST_HELD_P,
    ST_HELD_E
  } st_e;

  localparam int ERR_ILGL = 0;
  localparam int ERR_PRG  = 1;
  localparam int ERR_ERS  = 2;
  localparam int ERR_INT  = 3;
  localparam int N_ERR    = 4;

endpackage

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int CNT_W       = 6,
  parameter int SUS_RDY_CYC = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic [CNT_W-1:0] rem,
  output logic             last,
  output logic             susp_ok
);

  localparam int ELW = $clog2(SUS_RDY_CYC + 2);

  logic [ELW-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem     <= '0;
      elapsed <= '0;
    end else if (load) begin
      rem     <= load_val;
      elapsed <= '0;
    end else if (run) begin
      if (rem != '0) rem <= rem - 1'b1;
      if (elapsed != ELW'(SUS_RDY_CYC)) elapsed <= elapsed + 1'b1;
    end
  end

  assign last    = (rem == CNT_W'(1));
  assign susp_ok = (elapsed == ELW'(SUS_RDY_CYC));

endmodule

// File: rtl/flash_seq_rst_hold.sv
module flash_seq_rst_hold #(
  parameter int RST_MIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ctl_reset,
  output logic hold_q,
  output logic err_clear
);

  localparam int HW = $clog2(RST_MIN + 1);

  logic [HW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= ctl_reset;
      if (!ctl_reset)                cnt <= '0;
      else if (cnt != HW'(RST_MIN))  cnt <= cnt + 1'b1;
    end
  end

  assign err_clear = ctl_reset && (cnt == HW'(RST_MIN - 1));

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_seq_pkg::*;
#(
  parameter int BLK_W     = 4,
  parameter int CNT_W     = 6,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 60,
  parameter int SUS_LAT   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [BLK_W-1:0] cmd_blk,
  input  logic             mode_wr,
  input  logic             mode_val,
  input  logic             hold,
  input  logic             err_clear,
  input  logic             array_fault,
  input  logic             ctl_fault,
  input  logic             tmr_last,
  input  logic [CNT_W-1:0] tmr_rem,
  input  logic             tmr_susp_ok,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_load_val,
  output logic             tmr_run,
  output st_e              st_q,
  output logic             mode_q,
  output logic [N_ERR-1:0] err_q
);

  localparam int LW = $clog2(SUS_LAT + 1);

  st_e              st_n;
  logic             mode_n;
  logic [LW-1:0]    lat_q, lat_n;
  logic [CNT_W-1:0] sav_q, sav_n;
  logic             kind_q, kind_n;
  logic [BLK_W-1:0] eblk_q, eblk_n;
  logic [N_ERR-1:0] err_set;
  logic             busy, cmd_ok;
  op_e              op;

  assign op     = op_e'(cmd_op);
  assign busy   = (st_q == ST_PROG) || (st_q == ST_ERASE) || (st_q == ST_PROG_IN_ES);
  assign cmd_ok = cmd_valid && mode_q && !(|err_q) && !hold && !mode_wr;

  always_comb begin
    st_n         = st_q;
    mode_n       = mode_q;
    lat_n        = lat_q;
    sav_n        = sav_q;
    kind_n       = kind_q;
    eblk_n       = eblk_q;
    tmr_load     = 1'b0;
    tmr_load_val = '0;
    tmr_run      = busy;
    err_set      = '0;

    // operation end, optionally with an array failure
    if (busy && tmr_last) begin
      st_n = (st_q == ST_PROG_IN_ES) ? ST_HELD_E : ST_IDLE;
      if (array_fault) begin
        if (st_q == ST_ERASE) err_set[ERR_ERS] = 1'b1;
        else                  err_set[ERR_PRG] = 1'b1;
      end
    end

    // suspend latency countdown
    if (st_q == ST_SUSP_WAIT) begin
      if (lat_q <= LW'(1)) st_n = kind_q ? ST_HELD_E : ST_HELD_P;
      else                 lat_n = lat_q - 1'b1;
    end

    if (cmd_ok) begin
      case (st_q)
        ST_IDLE: begin
          if (op == OP_PROG) begin
            st_n         = ST_PROG;
            tmr_load     = 1'b1;
            tmr_load_val = CNT_W'(PROG_CYC);
          end else if (op == OP_ERASE) begin
            st_n         = ST_ERASE;
            tmr_load     = 1'b1;
            tmr_load_val = CNT_W'(ERASE_CYC);
            eblk_n       = cmd_blk;
          end else begin
            err_set[ERR_ILGL] = 1'b1;
          end
        end
        ST_PROG, ST_ERASE: begin
          if (op == OP_SUSP && tmr_susp_ok) begin
            // on the last busy cycle the operation simply completes
            if (!tmr_last) begin
              st_n    = ST_SUSP_WAIT;
              tmr_run = 1'b0;
              lat_n   = LW'(SUS_LAT);
              sav_n   = tmr_rem;
              kind_n  = (st_q == ST_ERASE);
            end
          end else begin
            err_set[ERR_ILGL] = 1'b1;
          end
        end
        ST_HELD_P: begin
          if (op == OP_RESUME) begin
            st_n         = ST_PROG;
            tmr_load     = 1'b1;
            tmr_load_val = sav_q;
          end else begin
            err_set[ERR_ILGL] = 1'b1;
          end
        end
        ST_HELD_E: begin
          if (op == OP_RESUME) begin
            st_n         = ST_ERASE;
            tmr_load     = 1'b1;
            tmr_load_val = sav_q;
          end else if (op == OP_PROG && cmd_blk != eblk_q) begin
            st_n         = ST_PROG_IN_ES;
            tmr_load     = 1'b1;
            tmr_load_val = CNT_W'(PROG_CYC);
          end else begin
            err_set[ERR_ILGL] = 1'b1;
          end
        end
        default: err_set[ERR_ILGL] = 1'b1;
      endcase
    end

    // mode-entry writes
    if (mode_wr) begin
      if (mode_val) begin
        if (st_q == ST_IDLE) mode_n = 1'b1;
      end else if (st_q == ST_IDLE || st_q == ST_HELD_P || st_q == ST_HELD_E) begin
        mode_n = 1'b0;
        st_n   = ST_IDLE;
      end
    end

    if (ctl_fault) err_set[ERR_INT] = 1'b1;

    if (|err_set) begin
      st_n     = ST_IDLE;
      tmr_run  = 1'b0;
      tmr_load = 1'b0;
    end

    if (hold) begin
      st_n     = ST_IDLE;
      mode_n   = 1'b0;
      tmr_run  = 1'b0;
      tmr_load = 1'b0;
      err_set  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
      lat_q  <= '0;
      sav_q  <= '0;
      kind_q <= 1'b0;
      eblk_q <= '0;
    end else begin
      st_q   <= st_n;
      mode_q <= mode_n;
      lat_q  <= lat_n;
      sav_q  <= sav_n;
      kind_q <= kind_n;
      eblk_q <= eblk_n;
    end
  end

  for (genvar i = 0; i < N_ERR; i++) begin : g_err
    always_ff @(posedge clk) begin
      if (rst || err_clear) err_q[i] <= 1'b0;
      else if (err_set[i])  err_q[i] <= 1'b1;
    end
  end

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int BLK_W       = 4,
  parameter int PROG_CYC    = 20,
  parameter int ERASE_CYC   = 60,
  parameter int SUS_RDY_CYC = 5,
  parameter int SUS_LAT     = 3,
  parameter int RST_MIN     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [BLK_W-1:0] cmd_blk,
  input  logic             mode_wr,
  input  logic             mode_val,
  input  logic             ctl_reset,
  input  logic             array_fault,
  input  logic             ctl_fault,
  output logic             mode_entry,
  output logic             rd_en,
  output logic             st_ready,
  output logic             st_susp_ok,
  output logic             st_prg_held,
  output logic             st_ers_held,
  output logic             err_illegal,
  output logic             err_prog,
  output logic             err_erase,
  output logic             err_internal
);

  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             hold_q, err_clear;
  logic             tmr_load, tmr_run, tmr_last, tmr_susp_ok;
  logic [CNT_W-1:0] tmr_load_val, tmr_rem;
  st_e              st_q;
  logic             mode_q;
  logic [N_ERR-1:0] err_q;

  flash_seq_rst_hold #(.RST_MIN(RST_MIN)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .ctl_reset (ctl_reset),
    .hold_q    (hold_q),
    .err_clear (err_clear)
  );

  flash_seq_timer #(.CNT_W(CNT_W), .SUS_RDY_CYC(SUS_RDY_CYC)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_load_val),
    .run      (tmr_run),
    .rem      (tmr_rem),
    .last     (tmr_last),
    .susp_ok  (tmr_susp_ok)
  );

  flash_seq_fsm #(
    .BLK_W(BLK_W), .CNT_W(CNT_W), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .SUS_LAT(SUS_LAT)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_blk      (cmd_blk),
    .mode_wr      (mode_wr),
    .mode_val     (mode_val),
    .hold         (ctl_reset),
    .err_clear    (err_clear),
    .array_fault  (array_fault),
    .ctl_fault    (ctl_fault),
    .tmr_last     (tmr_last),
    .tmr_rem      (tmr_rem),
    .tmr_susp_ok  (tmr_susp_ok),
    .tmr_load     (tmr_load),
    .tmr_load_val (tmr_load_val),
    .tmr_run      (tmr_run),
    .st_q         (st_q),
    .mode_q       (mode_q),
    .err_q        (err_q)
  );

  assign mode_entry   = mode_q;
  assign rd_en        = !mode_q && !hold_q;
  assign st_ready     = (st_q == ST_IDLE) || (st_q == ST_HELD_P) || (st_q == ST_HELD_E);
  assign st_susp_ok   = ((st_q == ST_PROG) || (st_q == ST_ERASE)) && tmr_susp_ok;
  assign st_prg_held  = (st_q == ST_HELD_P);
  assign st_ers_held  = (st_q == ST_HELD_E) || (st_q == ST_PROG_IN_ES);
  assign err_illegal  = err_q[ERR_ILGL];
  assign err_prog     = err_q[ERR_PRG];
  assign err_erase    = err_q[ERR_ERS];
  assign err_internal = err_q[ERR_INT];

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int BLK_W = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       mode_wr,
  input logic       ctl_reset,
  input logic       mode_entry,
  input logic       rd_en,
  input logic       st_ready,
  input logic       st_susp_ok,
  input logic       st_prg_held,
  input logic       st_ers_held,
  input logic       err_illegal,
  input logic       err_prog,
  input logic       err_erase,
  input logic       err_internal
);

  logic any_err, cmd_taken;
  assign any_err   = err_illegal | err_prog | err_erase | err_internal;
  assign cmd_taken = cmd_valid && mode_entry && !any_err && !ctl_reset && !mode_wr;

  // R3
  prog_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_taken && cmd_op == 3'd1 && st_ready && !st_prg_held && !st_ers_held) |=> !st_ready);

  // R4
  susp_ok_busy_chk: assert property (@(posedge clk) disable iff (rst)
    st_susp_ok |-> !st_ready);

  // R7
  resume_clears_held_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_taken && cmd_op == 3'd4 && st_prg_held) |=> (!st_ready && !st_prg_held));

  // R8
  resume_unheld_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_taken && cmd_op == 3'd4 && !st_prg_held && !st_ers_held) |=> err_illegal);

  // R11
  lock_idle_chk: assert property (@(posedge clk) disable iff (rst)
    any_err |-> (st_ready && !st_prg_held && !st_ers_held));

  // R11
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_illegal && !ctl_reset) |=> err_illegal);

  // R12
  hold_blocks_read_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_reset |=> (!mode_entry && !rd_en));

endmodule

bind flash_seq flash_seq_chk #(.BLK_W(BLK_W)) u_chk (.*);

// File: tb/flash_seq_bench.sv
module flash_seq_bench;

  localparam int BLK_W = 4, PROG_CYC = 20, ERASE_CYC = 60;
  localparam int SUS_RDY_CYC = 5, SUS_LAT = 3, RST_MIN = 4;
  localparam logic [2:0] C_PROG = 3'd1, C_ERASE = 3'd2, C_SUSP = 3'd3, C_RES = 3'd4;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 0, mode_wr = 0, mode_val = 0, ctl_reset = 0, array_fault = 0, ctl_fault = 0;
  logic [2:0] cmd_op = '0;
  logic [BLK_W-1:0] cmd_blk = '0;
  logic mode_entry, rd_en, st_ready, st_susp_ok, st_prg_held, st_ers_held;
  logic err_illegal, err_prog, err_erase, err_internal;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_seq #(.BLK_W(BLK_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
              .SUS_RDY_CYC(SUS_RDY_CYC), .SUS_LAT(SUS_LAT), .RST_MIN(RST_MIN)) u_flash_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .mode_wr(mode_wr), .mode_val(mode_val), .ctl_reset(ctl_reset),
    .array_fault(array_fault), .ctl_fault(ctl_fault),
    .mode_entry(mode_entry), .rd_en(rd_en), .st_ready(st_ready), .st_susp_ok(st_susp_ok),
    .st_prg_held(st_prg_held), .st_ers_held(st_ers_held), .err_illegal(err_illegal),
    .err_prog(err_prog), .err_erase(err_erase), .err_internal(err_internal));

  function automatic int left_after_suspend(int total, int ran);
    return total - ran;
  endfunction

  function automatic int errs();
    return {28'd0, err_internal, err_erase, err_prog, err_illegal};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(logic [2:0] op, logic [BLK_W-1:0] blk);
    cmd_valid = 1; cmd_op = op; cmd_blk = blk;
    @(negedge clk);
    cmd_valid = 0; cmd_op = '0;
  endtask

  task automatic set_mode(logic v);
    mode_wr = 1; mode_val = v;
    @(negedge clk);
    mode_wr = 0;
  endtask

  task automatic hold_reset(int n);
    ctl_reset = 1;
    tick(n);
    ctl_reset = 0;
    @(negedge clk);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!st_ready && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int n;
    void'($urandom(32'd4711));
    tick(3);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", st_ready, 1);
    chk("R1 flags", {st_susp_ok, st_prg_held, st_ers_held, mode_entry}, 0);
    chk("R1 errors", errs(), 0);
    chk("R1 rd_en", rd_en, 1);

    // R2 command without mode entry ignored
    issue(C_PROG, 4'd1);
    chk("R2 ignored ready", st_ready, 1);
    chk("R2 ignored err", errs(), 0);
    set_mode(1);
    chk("R2 mode entry", mode_entry, 1);
    chk("R2 rd_en off", rd_en, 0);

    // R3 program and erase durations
    issue(C_PROG, 4'd3);
    chk("R3 busy", st_ready, 0);
    wait_ready(n);
    chk("R3 program length", n, PROG_CYC);
    issue(C_ERASE, 4'd3);
    wait_ready(n);
    chk("R3 erase length", n, ERASE_CYC);

    // R4 suspend-ready timing, R5 suspend latency
    issue(C_ERASE, 4'd2);
    chk("R4 not yet", st_susp_ok, 0);
    tick(SUS_RDY_CYC - 1);
    chk("R4 one short", st_susp_ok, 0);
    tick(1);
    chk("R4 reached", st_susp_ok, 1);
    tick(3);
    issue(C_SUSP, 4'd0);
    chk("R5 latency ready", st_ready, 0);
    chk("R5 latency held", st_ers_held, 0);
    tick(SUS_LAT - 1);
    chk("R5 latency end ready", st_ready, 0);
    tick(1);
    chk("R5 held flags", {st_ready, st_prg_held, st_ers_held}, 3'b101);

    // R9 program other block while erase held
    issue(C_PROG, 4'd7);
    chk("R9 busy", {st_ready, st_ers_held}, 2'b01);
    wait_ready(n);
    chk("R9 length", n, PROG_CYC);
    chk("R9 back to held", {st_ers_held, errs() != 0}, 2'b10);

    // R7 erase resume with remaining count
    issue(C_RES, 4'd0);
    chk("R7 resume flags", {st_ready, st_ers_held}, 0);
    wait_ready(n);
    chk("R7 erase remainder", n, left_after_suspend(ERASE_CYC, SUS_RDY_CYC + 3));

    // R5/R7 program suspend and resume
    issue(C_PROG, 4'd4);
    tick(6);
    issue(C_SUSP, 4'd0);
    tick(SUS_LAT);
    chk("R5 program held", {st_ready, st_prg_held, st_ers_held}, 3'b110);
    issue(C_RES, 4'd0);
    wait_ready(n);
    chk("R7 program remainder", n, left_after_suspend(PROG_CYC, 6));

    // R6 suspend on last busy cycle
    issue(C_PROG, 4'd4);
    tick(PROG_CYC - 1);
    issue(C_SUSP, 4'd0);
    chk("R6 race flags", {st_ready, st_prg_held, st_ers_held}, 3'b100);
    tick(SUS_LAT + 1);
    chk("R6 race no error", errs(), 0);
    chk("R6 race still idle", {st_ready, st_prg_held}, 2'b10);

    // R10 mode clear from held erase, then R8 resume illegal
    issue(C_ERASE, 4'd9);
    tick(6);
    issue(C_SUSP, 4'd0);
    tick(SUS_LAT);
    set_mode(0);
    chk("R10 read mode", {mode_entry, rd_en, st_ready, st_ers_held}, 4'b0110);
    set_mode(1);
    issue(C_RES, 4'd0);
    chk("R8 resume unheld", err_illegal, 1);
    // R11 locked: program ignored
    issue(C_PROG, 4'd1);
    tick(2);
    chk("R11 command ignored", {st_ready, st_prg_held, st_ers_held}, 3'b100);

    // R12 short pulse keeps errors, full pulse clears
    ctl_reset = 1;
    @(negedge clk);
    chk("R12 read disabled", {rd_en, mode_entry}, 0);
    tick(RST_MIN - 2);
    ctl_reset = 0;
    @(negedge clk);
    chk("R12 short pulse", err_illegal, 1);
    chk("R12 rd_en after", rd_en, 1);
    set_mode(1);
    ctl_reset = 1; cmd_valid = 1; cmd_op = C_PROG;
    @(negedge clk);
    cmd_valid = 0;
    chk("R12 cmd ignored in hold", {st_ready, mode_entry}, 2'b10);
    tick(RST_MIN - 1);
    ctl_reset = 0;
    @(negedge clk);
    chk("R12 full pulse clears", errs(), 0);

    // R4 early suspend illegal
    set_mode(1);
    issue(C_PROG, 4'd2);
    tick(2);
    issue(C_SUSP, 4'd0);
    chk("R4 early suspend", {err_illegal, st_ready}, 2'b11);
    hold_reset(RST_MIN);
    // R4 suspend after completion illegal
    set_mode(1);
    issue(C_PROG, 4'd2);
    wait_ready(n);
    issue(C_SUSP, 4'd0);
    chk("R4 late suspend", err_illegal, 1);
    hold_reset(RST_MIN);
    // R3 unknown code illegal
    set_mode(1);
    issue(3'd6, 4'd0);
    chk("R3 bad code", err_illegal, 1);
    hold_reset(RST_MIN);

    // R9 program to erase target illegal
    set_mode(1);
    issue(C_ERASE, 4'd5);
    tick(6);
    issue(C_SUSP, 4'd0);
    tick(SUS_LAT);
    issue(C_PROG, 4'd5);
    chk("R9 target program", {err_illegal, st_ers_held}, 2'b10);
    hold_reset(RST_MIN);

    // R13 array and controller faults
    set_mode(1);
    issue(C_PROG, 4'd1);
    tick(PROG_CYC - 1);
    array_fault = 1;
    @(negedge clk);
    array_fault = 0;
    chk("R13 program fault", errs(), 2);
    hold_reset(RST_MIN);
    set_mode(1);
    issue(C_ERASE, 4'd1);
    tick(ERASE_CYC - 1);
    array_fault = 1;
    @(negedge clk);
    array_fault = 0;
    chk("R13 erase fault", errs(), 4);
    hold_reset(RST_MIN);
    ctl_fault = 1;
    @(negedge clk);
    ctl_fault = 0;
    chk("R13 internal fault", errs(), 8);
    hold_reset(RST_MIN);
    chk("R12 cleared after fault", errs(), 0);

    // R7 random suspend points and operations
    set_mode(1);
    for (int it = 0; it < 10; it++) begin
      bit is_er = $urandom_range(1, 0) != 0;
      int dur = is_er ? ERASE_CYC : PROG_CYC;
      int w = SUS_RDY_CYC + int'($urandom_range(dur - SUS_RDY_CYC - 2, 0));
      issue(is_er ? C_ERASE : C_PROG, BLK_W'($urandom_range(15, 0)));
      tick(w);
      issue(C_SUSP, 4'd0);
      tick(SUS_LAT);
      chk("R5 random held", {st_prg_held, st_ers_held}, is_er ? 1 : 2);
      tick(int'($urandom_range(4, 0)));
      issue(C_RES, 4'd0);
      wait_ready(n);
      chk("R7 random remainder", n, left_after_suspend(dur, w));
      chk("R7 random no error", errs(), 0);
    end

    report();
  end

endmodule